// File: doc/BRIEF.md
# Three-Stage Core Watchdog

This block guards one processor core. Software programs a reload length and an escalation mode, then pokes the block regularly. A 24-bit down-counter advances once per prescaled tick. Each time it runs out before a poke arrives, the watchdog moves one stage further. The first expiry raises a level interrupt. The second adds a level non-maskable interrupt. The third issues a single-cycle request for a chip-wide soft reset and then parks the block.

The 16-bit length supplies the upper bits of the counter, and the lower 8 bits reload as zero. One period is therefore `length * 256 * PRESCALE` clocks. Software can read the running count and the stage at any time. This lets it see how much of the period remains and how far escalation has gone.

Top module: `wdog_escalator`

## Requirements
- R1: After `rst_n` is low, the block is disabled (mode 0, length 0). `stage_o` is 0, `cnt_o` is 0, and `irq_o`, `nmi_o` and `rst_req_o` are low.
- R2: A restart loads `cnt_o` with `{length, 8'h00}`. While the block is enabled, `cnt_o` decrements once every PRESCALE clocks. It reads 1 on the last tick of a period, so a period lasts `length*256*PRESCALE` clocks, and at expiry the count reloads.
- R3: Stage codes are 0 idle, 1 interrupt, 2 NMI and 3 reset. Each expiry advances the stage by exactly one. `irq_o` is high in stages 1 to 3, and `nmi_o` is high in stages 2 and 3.
- R4: `rst_req_o` pulses high for exactly one clock, on the edge where the stage becomes 3. In stage 3 the count stops and holds, and a poke is ignored. Only reset or a configuration write leaves stage 3.
- R5: Mode codes are 0 off, 1 interrupt only, 2 interrupt plus NMI, and 3 all three stages. In modes 1 and 2 the stage stops at the last enabled stage, while the count keeps reloading at each expiry.
- R6: A poke outside stage 3, while the block is enabled, reloads the count and returns the stage to 0 on the same edge. This drops `irq_o` and `nmi_o`.
- R7: A configuration write with a nonzero mode and a nonzero length reloads the count from the new length and clears the stage to 0, including from stage 3.
- R8: When the mode is 0 or the length is 0, the block is disabled. `cnt_o` reads 0, the stage is 0, all outputs are low, and pokes have no effect. Writing such a configuration clears any active outputs.
- R9: If a poke or a configuration write falls on the same edge as an expiry, the restart wins and the stage does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_len | input | 16 | Reload length (upper counter bits) |
| cfg_mode | input | 2 | Escalation mode |
| poke | input | 1 | Service strobe, restarts the period |
| cnt_o | output | 24 | Current counter value |
| stage_o | output | 2 | Current escalation stage |
| irq_o | output | 1 | Level interrupt |
| nmi_o | output | 1 | Level non-maskable interrupt |
| rst_req_o | output | 1 | One-cycle soft-reset request |

## Verification
A poke and a period expiry can fall on the same clock edge, and the block must then treat the edge as a restart and not an escalation. The bench provokes this by configuring a one-unit length, counting exactly one clock short of the expiry edge, and asserting the poke so that it is sampled on that edge. It then expects stage 0, a low interrupt and a freshly loaded count. The same collision is repeated with a configuration write in place of the poke.

// File: rtl/wdog_pkg.sv
// Package: shared encodings for the escalating watchdog.
// Assumes a 2-bit stage and a 2-bit mode, whose numeric values are visible to software.
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_IRQ  = 2'd1,
        ST_NMI  = 2'd2,
        ST_RST  = 2'd3
    } wd_stage_e;

    typedef enum logic [1:0] {
        MD_OFF  = 2'd0,
        MD_IRQ  = 2'd1,
        MD_NMI  = 2'd2,
        MD_FULL = 2'd3
    } wd_mode_e;
endpackage

// File: rtl/wdog_prescaler.sv
// Prescaler: emits one tick every DIV clocks while run is high.
// Assumes DIV >= 1. The clear input restarts the phase so that a period begins on a known edge.
module wdog_prescaler #(
    parameter int DIV = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    generate
        if (DIV == 1) begin : g_bypass
            // Every clock is a tick when no division is needed.
            assign tick = run && !clear;
        end else begin : g_count
            localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase_q;

            // Phase counter, held at zero when idle or restarted.
            always_ff @(posedge clk) begin
                if (!rst_n)              phase_q <= '0;
                else if (clear || !run)  phase_q <= '0;
                else if (phase_q == LAST) phase_q <= '0;
                else                     phase_q <= phase_q + 1'b1;
            end

            assign tick = run && !clear && (phase_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/wdog_decrementer.sv
// Decrementer: holds the period count, steps it on ticks and flags expiry.
// Assumes reload_val is nonzero whenever en is high. Priority: load, disable, hold, tick.
module wdog_decrementer #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          hold,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] reload_val,
    input  logic          tick,
    output logic [CW-1:0] cnt,
    output logic          expire
);
    logic last_tick;
    assign last_tick = (cnt <= CW'(1));
    assign expire    = en && !hold && !load && tick && last_tick;

    // Count register: load on restart, zero when disabled, reload at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (load)   cnt <= load_val;
        else if (!en)    cnt <= '0;
        else if (hold)   cnt <= cnt;
        else if (tick)   cnt <= last_tick ? reload_val : cnt - 1'b1;
    end
endmodule

// File: rtl/wdog_stage_fsm.sv
// Stage sequencer: walks idle, interrupt, NMI and reset on expiries, capped by the mode.
// Assumes restart already excludes pokes that arrive in the terminal stage.
module wdog_stage_fsm
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      restart,
    input  logic      expire,
    input  wd_mode_e  mode,
    output wd_stage_e stage,
    output logic      rst_pulse
);
    wd_stage_e cap;
    assign cap = wd_stage_e'(mode);

    // Stage register and one-cycle reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage     <= ST_IDLE;
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= 1'b0;
            if (restart || !en) begin
                stage <= ST_IDLE;
            end else if (expire && (stage < cap)) begin
                stage <= wd_stage_e'(stage + 2'd1);
                if (stage == ST_NMI) rst_pulse <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdog_escalator.sv
// Top: one core's escalating watchdog with a configuration register, poke and readback.
// Assumes single-cycle strobes. A configuration write takes precedence over a poke on the same edge.
module wdog_escalator
    import wdog_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int FRAC_W   = 8,
    parameter int PRESCALE = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [LEN_W-1:0]        cfg_len,
    input  logic [1:0]              cfg_mode,
    input  logic                    poke,
    output logic [LEN_W+FRAC_W-1:0] cnt_o,
    output logic [1:0]              stage_o,
    output logic                    irq_o,
    output logic                    nmi_o,
    output logic                    rst_req_o
);
    localparam int CW = LEN_W + FRAC_W;

    wd_mode_e         mode_q;
    logic [LEN_W-1:0] len_q;
    wd_stage_e        stage;
    logic             en, new_en, terminal, poke_eff, restart, tick, expire;
    logic [CW-1:0]    load_val, reload_val;

    // Configuration register: mode and length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_OFF;
            len_q  <= '0;
        end else if (cfg_wr) begin
            mode_q <= wd_mode_e'(cfg_mode);
            len_q  <= cfg_len;
        end
    end

    assign en         = (mode_q != MD_OFF) && (len_q != '0);
    assign new_en     = (cfg_mode != 2'd0) && (cfg_len != '0);
    assign terminal   = (stage == ST_RST);
    assign poke_eff   = poke && en && !terminal;
    assign restart    = cfg_wr || poke_eff;
    assign reload_val = {len_q, {FRAC_W{1'b0}}};
    assign load_val   = cfg_wr ? (new_en ? {cfg_len, {FRAC_W{1'b0}}} : '0) : reload_val;

    wdog_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en && !terminal),
        .clear (restart),
        .tick  (tick)
    );

    wdog_decrementer #(.CW(CW)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .hold       (terminal),
        .load       (restart),
        .load_val   (load_val),
        .reload_val (reload_val),
        .tick       (tick),
        .cnt        (cnt_o),
        .expire     (expire)
    );

    wdog_stage_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .restart   (restart),
        .expire    (expire),
        .mode      (mode_q),
        .stage     (stage),
        .rst_pulse (rst_req_o)
    );

    assign stage_o = stage;
    assign irq_o   = (stage != ST_IDLE);
    assign nmi_o   = (stage == ST_NMI) || (stage == ST_RST);
endmodule

// File: rtl/wdog_escalator_chk.sv
// Checker: temporal properties of the watchdog's ports and mode register, bound to the top.
module wdog_escalator_chk #(
    parameter int CW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic          poke,
    input logic [1:0]    mode_q,
    input logic [CW-1:0] cnt_o,
    input logic [1:0]    stage_o,
    input logic          irq_o,
    input logic          nmi_o,
    input logic          rst_req_o
);
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rst_req_o |=> !rst_req_o); // R4
    AST_RST_IN_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n) rst_req_o |-> (stage_o == 2'd3)); // R4
    AST_TERMINAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (stage_o == 2'd3) && !cfg_wr |=> (stage_o == 2'd3)); // R4
    AST_NMI_HAS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) nmi_o |-> irq_o); // R3
    AST_STAGE_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n) (stage_o != $past(stage_o)) && (stage_o != 2'd0) |-> (stage_o == $past(stage_o) + 2'd1)); // R3
    AST_STAGE_CAPPED: assert property (@(posedge clk) disable iff (!rst_n) stage_o <= mode_q); // R5
    AST_POKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) poke && !cfg_wr && (stage_o != 2'd3) |=> (stage_o == 2'd0)); // R6
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == 2'd0) |-> (cnt_o == '0) && !irq_o && !nmi_o && !rst_req_o); // R8
endmodule

bind wdog_escalator wdog_escalator_chk #(.CW(LEN_W + FRAC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .poke      (poke),
    .mode_q    (mode_q),
    .cnt_o     (cnt_o),
    .stage_o   (stage_o),
    .irq_o     (irq_o),
    .nmi_o     (nmi_o),
    .rst_req_o (rst_req_o)
);

// File: tb/wdog_escalator_tb_top.sv
`timescale 1ns/1ps
// Bench: a vector table of configure-wait-compare runs, then directed collision, terminal and reset tests.
// PRESCALE is 2, so a length of 1 gives a 512-clock period.
module wdog_escalator_tb_top;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_len = '0;
    logic [1:0]  cfg_mode = '0;
    logic        poke = 1'b0;
    logic [23:0] cnt_o;
    logic [1:0]  stage_o;
    logic        irq_o, nmi_o, rst_req_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    wdog_escalator #(.LEN_W(16), .FRAC_W(8), .PRESCALE(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_len(cfg_len), .cfg_mode(cfg_mode),
        .poke(poke), .cnt_o(cnt_o), .stage_o(stage_o), .irq_o(irq_o), .nmi_o(nmi_o),
        .rst_req_o(rst_req_o)
    );

    typedef struct packed {
        logic [15:0] len;
        logic [1:0]  mode;
        logic [15:0] wait_n;
        logic [1:0]  st;
        logic        irq;
        logic        nmi;
        logic        rst;
        logic [23:0] cnt;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{16'd1, 2'd3, 16'd10,   2'd0, 1'b0, 1'b0, 1'b0, 24'd251, 4'd2}, // R2 early count
        '{16'd1, 2'd3, 16'd511,  2'd0, 1'b0, 1'b0, 1'b0, 24'd1,   4'd2}, // R2 last tick
        '{16'd1, 2'd3, 16'd512,  2'd1, 1'b1, 1'b0, 1'b0, 24'd256, 4'd3}, // R3 first expiry
        '{16'd1, 2'd3, 16'd1024, 2'd2, 1'b1, 1'b1, 1'b0, 24'd256, 4'd3}, // R3 second expiry
        '{16'd1, 2'd3, 16'd1536, 2'd3, 1'b1, 1'b1, 1'b1, 24'd256, 4'd4}, // R4 reset pulse
        '{16'd1, 2'd3, 16'd1537, 2'd3, 1'b1, 1'b1, 1'b0, 24'd256, 4'd4}, // R4 pulse gone
        '{16'd1, 2'd1, 16'd1536, 2'd1, 1'b1, 1'b0, 1'b0, 24'd256, 4'd5}, // R5 mode 1 cap
        '{16'd1, 2'd2, 16'd2048, 2'd2, 1'b1, 1'b1, 1'b0, 24'd256, 4'd5}, // R5 mode 2 cap
        '{16'd2, 2'd3, 16'd1023, 2'd0, 1'b0, 1'b0, 1'b0, 24'd1,   4'd2}, // R2 longer length
        '{16'd2, 2'd3, 16'd1024, 2'd1, 1'b1, 1'b0, 1'b0, 24'd512, 4'd2}, // R2 longer expiry
        '{16'd0, 2'd3, 16'd600,  2'd0, 1'b0, 1'b0, 1'b0, 24'd0,   4'd8}, // R8 zero length
        '{16'd5, 2'd0, 16'd600,  2'd0, 1'b0, 1'b0, 1'b0, 24'd0,   4'd8}, // R8 mode off
        '{16'd1, 2'd2, 16'd600,  2'd1, 1'b1, 1'b0, 1'b0, 24'd212, 4'd5}  // R5 reload count
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [1:0] st, input logic irq,
                             input logic nmi, input logic rst, input logic [23:0] cnt);
        check({tag, " stage"}, 32'(stage_o), 32'(st));
        check({tag, " irq"}, 32'(irq_o), 32'(irq));
        check({tag, " nmi"}, 32'(nmi_o), 32'(nmi));
        check({tag, " rstreq"}, 32'(rst_req_o), 32'(rst));
        check({tag, " count"}, 32'(cnt_o), 32'(cnt));
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_cfg(input logic [15:0] len, input logic [1:0] mode);
        cfg_wr = 1'b1; cfg_len = len; cfg_mode = mode;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_poke();
        poke = 1'b1;
        @(posedge clk);
        @(negedge clk);
        poke = 1'b0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset state", 2'd0, 1'b0, 1'b0, 1'b0, 24'd0);

        for (int i = 0; i < NV; i++) begin
            do_cfg(VECS[i].len, VECS[i].mode);
            wait_cyc(int'(VECS[i].wait_n));
            check_all($sformatf("R%0d vector %0d", VECS[i].req, i),
                      VECS[i].st, VECS[i].irq, VECS[i].nmi, VECS[i].rst, VECS[i].cnt);
        end

        // R6: a poke in stage 1 returns to idle and restarts the period.
        do_cfg(16'd1, 2'd3);
        wait_cyc(600);
        check_all("R3 before poke", 2'd1, 1'b1, 1'b0, 1'b0, 24'd212);
        do_poke();
        check_all("R6 poke clears", 2'd0, 1'b0, 1'b0, 1'b0, 24'd256);
        wait_cyc(511);
        check_all("R2 after poke", 2'd0, 1'b0, 1'b0, 1'b0, 24'd1);
        wait_cyc(1);
        check_all("R2 re-expiry", 2'd1, 1'b1, 1'b0, 1'b0, 24'd256);

        // R9: a poke on the expiry edge wins.
        do_cfg(16'd1, 2'd3);
        wait_cyc(511);
        do_poke();
        check_all("R9 poke at expiry", 2'd0, 1'b0, 1'b0, 1'b0, 24'd256);

        // R9: a configuration write on the expiry edge wins.
        do_cfg(16'd1, 2'd3);
        wait_cyc(511);
        do_cfg(16'd1, 2'd3);
        check_all("R9 cfg at expiry", 2'd0, 1'b0, 1'b0, 1'b0, 24'd256);

        // R4: in the terminal stage a poke is ignored and the count holds.
        do_cfg(16'd1, 2'd3);
        wait_cyc(1537);
        do_poke();
        check_all("R4 poke ignored", 2'd3, 1'b1, 1'b1, 1'b0, 24'd256);
        wait_cyc(700);
        check_all("R4 terminal hold", 2'd3, 1'b1, 1'b1, 1'b0, 24'd256);

        // R7: a configuration write leaves the terminal stage.
        do_cfg(16'd1, 2'd2);
        check_all("R7 reconfig", 2'd0, 1'b0, 1'b0, 1'b0, 24'd256);
        wait_cyc(1024);
        check_all("R5 mode 2 nmi", 2'd2, 1'b1, 1'b1, 1'b0, 24'd256);

        // R8: disabling clears active levels, and later pokes do nothing.
        do_cfg(16'd1, 2'd0);
        check_all("R8 disable clears", 2'd0, 1'b0, 1'b0, 1'b0, 24'd0);
        do_poke();
        wait_cyc(600);
        check_all("R8 stays quiet", 2'd0, 1'b0, 1'b0, 1'b0, 24'd0);

        // R1: reset in mid-run returns to the disabled state.
        do_cfg(16'd1, 2'd3);
        wait_cyc(600);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(600);
        check_all("R1 reset mid-run", 2'd0, 1'b0, 1'b0, 1'b0, 24'd0);

        finish_run();
    end
endmodule